// File: doc/BRIEF.md
# Crystal-Driven Phase and Time-State Sequencer with External Alignment

This block divides the crystal clock into the phase and time-state sequence of a small controller core. Every rising edge of the crystal clock moves the phase on by one. After the last phase, the time state advances. After the last time state, a new machine cycle begins and a one-clock cycle strobe marks it. With the default build, a machine cycle is 5 time states of 3 phases each, which is 15 clocks. A run enable tells the core when it may execute: the core reset must be released, and five whole machine cycles must have passed since the sequencer was last aligned.

A tester or a companion controller can align the sequencer from outside. It holds the sync-enable level high, which stands for a detected high voltage on the sync pin. It then gives a long enough high pulse on the sync pin. While the pulse lasts, the sequencer is held in a cleared state. A fixed number of clocks after the pulse falls, the sequencer restarts at time state 1, phase 1. A pulse that is too short leaves the sequence alone and raises an abort flag. When sync-enable is low, the sync pin does nothing.

Top module: `xtal_state_gen`

## Requirements
- R1: While `rst` is sampled high, the outputs are loaded with `tstate`=1, `phase`=1, `cyc_stb`=1, `run_en`=0 and `sync_abort`=0. The reset edge counts as an alignment.
- R2: When nothing is holding it, `phase` counts 1,2,3,1 on each clock, and `tstate` steps by one when `phase` wraps, going from 5 back to 1. `cyc_stb` is 1 exactly when the outputs show `tstate`=1 and `phase`=1 after an advance or an alignment. This makes one strobe every 15 clocks.
- R3: On any edge where `sync_en` is sampled low, `t0` has no effect: the sequence keeps advancing and `sync_abort` does not change.
- R4: A rising `t0` counts only if `sync_en` was sampled high on at least the 4 edges before the edge where the high `t0` is first seen. An earlier rise is ignored, even if `t0` then stays high.
- R5: On the edge that samples the 4th consecutive high `t0` of an accepted pulse, the sequencer is cleared: `tstate`=0, `phase`=0, `cyc_stb`=0 and `run_en`=0. It stays cleared while `t0` stays high. The value 0 means held.
- R6: Let f be the first edge after clearing that samples `t0` low. The outputs stay cleared after edge f+1. After edge f+2 they show `tstate`=1, `phase`=1, `cyc_stb`=1, and normal counting resumes from there.
- R7: An accepted pulse whose `t0` is sampled low before its 4th high sample leaves `tstate` and `phase` on their normal course and sets `sync_abort` on that edge. The flag stays set until the next accepted rise or `rst`.
- R8: After an edge, `run_en` is 1 only if `core_rst` was sampled low on that edge and at least 75 edges have passed since the last alignment with no clearing in between.
- R9: If `sync_en` is sampled low while the sequencer is cleared or waiting to realign, the sequencer aligns on that edge: `tstate`=1, `phase`=1, `cyc_stb`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the block |
| sync_en | input | 1 | Sync mode level (high-voltage detect on the sync pin) |
| t0 | input | 1 | Sync pulse pin |
| core_rst | input | 1 | Core reset pin, high holds the core |
| tstate | output | 3 | Time state, 1 to 5; 0 while held |
| phase | output | 2 | Phase within the time state, 1 to 3; 0 while held |
| cyc_stb | output | 1 | First clock of a machine cycle |
| run_en | output | 1 | Core may execute |
| sync_abort | output | 1 | Last accepted sync pulse was too short |

## Verification
The bench builds the block with its default parameters: 3 phases, 5 time states, an arming lead of 4, a minimum pulse of 4, a realignment delay of 2 and a warm-up of 5 cycles. These values put the full 75-clock run-enable window and several wraps of the 15-clock cycle inside a short run. They also place the arming boundary one clock early and the minimum-pulse boundary one clock short, so both can be driven exactly. A behavioural model that counts in plain integers is compared with every output on every clock. Directed checks sit on the edges where the cleared state, the realignment and the abort flag must appear.

// File: rtl/xsg_pkg.sv
package xsg_pkg;

  typedef enum logic [1:0] {
    SY_IDLE,
    SY_PEND,
    SY_HOLD,
    SY_ALIGN
  } sync_st_e;

  // width of a counter that must hold the value n
  function automatic int unsigned cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/xsg_arm.sv
module xsg_arm
  import xsg_pkg::*;
#(
  parameter int unsigned LEAD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_en,
  input  logic t0,
  output logic rise_ok
);

  localparam int unsigned EW = cw(LEAD);

  logic [EW-1:0] en_cnt;
  logic          t0_q;

  // clocks spent in sync mode, saturating at LEAD
  always_ff @(posedge clk) begin
    if (rst) begin
      en_cnt <= '0;
      t0_q   <= 1'b0;
    end else begin
      t0_q <= t0;
      if (!sync_en)
        en_cnt <= '0;
      else if (en_cnt != EW'(LEAD))
        en_cnt <= en_cnt + 1'b1;
    end
  end

  assign rise_ok = sync_en && (en_cnt == EW'(LEAD)) && t0 && !t0_q;

endmodule

// File: rtl/xsg_sync.sv
module xsg_sync
  import xsg_pkg::*;
#(
  parameter int unsigned MIN_HI = 4,
  parameter int unsigned DLY    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_en,
  input  logic t0,
  input  logic rise_ok,
  output logic hold,
  output logic load,
  output logic abort
);

  localparam int unsigned HW = cw(MIN_HI);
  localparam int unsigned DW = cw(DLY);

  sync_st_e      st, st_n;
  logic [HW-1:0] hi, hi_n;
  logic [DW-1:0] dly, dly_n;
  logic          ab_n;

  always_comb begin
    st_n  = st;
    hi_n  = hi;
    dly_n = dly;
    ab_n  = abort;
    hold  = 1'b0;
    load  = 1'b0;
    if (!sync_en) begin
      st_n = SY_IDLE;
      load = (st == SY_HOLD) || (st == SY_ALIGN);
    end else begin
      unique case (st)
        SY_IDLE: begin
          if (rise_ok) begin
            ab_n = 1'b0;
            hi_n = HW'(1);
            if (MIN_HI <= 1) begin
              st_n = SY_HOLD;
              hold = 1'b1;
            end else begin
              st_n = SY_PEND;
            end
          end
        end
        SY_PEND: begin
          if (t0) begin
            hi_n = hi + 1'b1;
            if (HW'(hi + 1'b1) == HW'(MIN_HI)) begin
              st_n = SY_HOLD;
              hold = 1'b1;
            end
          end else begin
            st_n = SY_IDLE;
            ab_n = 1'b1;
          end
        end
        SY_HOLD: begin
          hold = 1'b1;
          if (!t0) begin
            st_n  = SY_ALIGN;
            dly_n = DW'(DLY - 1);
          end
        end
        SY_ALIGN: begin
          if (dly == '0) begin
            load = 1'b1;
            st_n = SY_IDLE;
          end else begin
            hold  = 1'b1;
            dly_n = dly - 1'b1;
          end
        end
        default: st_n = SY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SY_IDLE;
      hi    <= '0;
      dly   <= '0;
      abort <= 1'b0;
    end else begin
      st    <= st_n;
      hi    <= hi_n;
      dly   <= dly_n;
      abort <= ab_n;
    end
  end

endmodule

// File: rtl/xsg_seq.sv
module xsg_seq
  import xsg_pkg::*;
#(
  parameter int unsigned PHASES = 3,
  parameter int unsigned STATES = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hold,
  input  logic                      load,
  output logic [cw(STATES)-1:0]     tstate,
  output logic [cw(PHASES)-1:0]     phase,
  output logic                      cyc_stb,
  output logic                      adv_stb
);

  localparam int unsigned TW = cw(STATES);
  localparam int unsigned PW = cw(PHASES);

  logic [TW-1:0] ts_n;
  logic [PW-1:0] ph_n;
  logic          ph_wrap;

  assign ph_wrap = (phase == PW'(PHASES));

  always_comb begin
    ph_n = ph_wrap ? PW'(1) : phase + 1'b1;
    ts_n = tstate;
    if (ph_wrap)
      ts_n = (tstate == TW'(STATES)) ? TW'(1) : tstate + 1'b1;
  end

  // a machine cycle begins by plain counting on this edge
  assign adv_stb = !hold && !load && ph_wrap && (tstate == TW'(STATES));

  always_ff @(posedge clk) begin
    if (rst || load) begin
      tstate  <= TW'(1);
      phase   <= PW'(1);
      cyc_stb <= 1'b1;
    end else if (hold) begin
      tstate  <= '0;
      phase   <= '0;
      cyc_stb <= 1'b0;
    end else begin
      tstate  <= ts_n;
      phase   <= ph_n;
      cyc_stb <= (ts_n == TW'(1)) && (ph_n == PW'(1));
    end
  end

endmodule

// File: rtl/xsg_warm.sv
module xsg_warm
  import xsg_pkg::*;
#(
  parameter int unsigned CYCLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic load,
  input  logic adv_stb,
  input  logic core_rst,
  output logic run_en
);

  localparam int unsigned CW = cw(CYCLES);

  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (load || hold)
      cnt_n = '0;
    else if (adv_stb && (cnt != CW'(CYCLES)))
      cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run_en <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      run_en <= !core_rst && (cnt_n == CW'(CYCLES));
    end
  end

endmodule

// File: rtl/xtal_state_gen.sv
module xtal_state_gen
  import xsg_pkg::*;
#(
  parameter int unsigned PHASES    = 3,
  parameter int unsigned STATES    = 5,
  parameter int unsigned EN_LEAD   = 4,
  parameter int unsigned SYNC_MIN  = 4,
  parameter int unsigned ALIGN_DLY = 2,
  parameter int unsigned WARM_CYC  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sync_en,
  input  logic                  t0,
  input  logic                  core_rst,
  output logic [cw(STATES)-1:0] tstate,
  output logic [cw(PHASES)-1:0] phase,
  output logic                  cyc_stb,
  output logic                  run_en,
  output logic                  sync_abort
);

  logic rise_ok;
  logic hold;
  logic load;
  logic adv_stb;

  xsg_arm #(.LEAD(EN_LEAD)) u_arm (
    .clk     (clk),
    .rst     (rst),
    .sync_en (sync_en),
    .t0      (t0),
    .rise_ok (rise_ok)
  );

  xsg_sync #(.MIN_HI(SYNC_MIN), .DLY(ALIGN_DLY)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sync_en (sync_en),
    .t0      (t0),
    .rise_ok (rise_ok),
    .hold    (hold),
    .load    (load),
    .abort   (sync_abort)
  );

  xsg_seq #(.PHASES(PHASES), .STATES(STATES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .load    (load),
    .tstate  (tstate),
    .phase   (phase),
    .cyc_stb (cyc_stb),
    .adv_stb (adv_stb)
  );

  xsg_warm #(.CYCLES(WARM_CYC)) u_warm (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .load     (load),
    .adv_stb  (adv_stb),
    .core_rst (core_rst),
    .run_en   (run_en)
  );

endmodule

// File: rtl/xtal_state_gen_chk.sv
module xtal_state_gen_chk #(
  parameter int unsigned PHASES = 3,
  parameter int unsigned STATES = 5,
  parameter int unsigned TW     = 3,
  parameter int unsigned PW     = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_en,
  input logic          core_rst,
  input logic [TW-1:0] tstate,
  input logic [PW-1:0] phase,
  input logic          cyc_stb,
  input logic          run_en,
  input logic          sync_abort
);

  // R2
  seq_range_chk: assert property (@(posedge clk) disable iff (rst)
    (tstate <= TW'(STATES)) && (phase <= PW'(PHASES)) && ((tstate == '0) == (phase == '0)));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sync_en) && ($past(phase) != '0) && ($past(phase) < PW'(PHASES)))
      |-> (phase == $past(phase) + 1'b1));

  // R2
  strobe_pos_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_stb |-> ((tstate == TW'(1)) && (phase == PW'(1))));

  // R5
  held_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |-> (!cyc_stb && !run_en));

  // R3
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> (phase != '0));

  // R8
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    run_en |-> !$past(core_rst));

  // R7
  abort_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_abort) |-> (phase != '0));

endmodule

bind xtal_state_gen xtal_state_gen_chk #(
  .PHASES (PHASES),
  .STATES (STATES),
  .TW     (xsg_pkg::cw(STATES)),
  .PW     (xsg_pkg::cw(PHASES))
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sync_en    (sync_en),
  .core_rst   (core_rst),
  .tstate     (tstate),
  .phase      (phase),
  .cyc_stb    (cyc_stb),
  .run_en     (run_en),
  .sync_abort (sync_abort)
);

// File: tb/sim_xtal_state_gen.sv
`timescale 1ns/1ps
module sim_xtal_state_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_en = 1'b0;
  logic       t0 = 1'b0;
  logic       core_rst = 1'b0;
  logic [2:0] tstate;
  logic [1:0] phase;
  logic       cyc_stb, run_en, sync_abort;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xtal_state_gen u0 (
    .clk(clk), .rst(rst), .sync_en(sync_en), .t0(t0), .core_rst(core_rst),
    .tstate(tstate), .phase(phase), .cyc_stb(cyc_stb), .run_en(run_en),
    .sync_abort(sync_abort)
  );

  // behavioural reference
  int m_ts, m_ph, m_stb, m_run, m_ab;
  int ecount, prev_t0, mode, hi, waitc, since;
  bit started = 0;

  always @(posedge clk) begin
    int act;  // 0 advance, 1 clear, 2 align
    bit rise;
    act = 0;
    if (rst) begin
      m_ts = 1; m_ph = 1; m_stb = 1; m_run = 0; m_ab = 0;
      ecount = 0; prev_t0 = 0; mode = 0; hi = 0; waitc = 0; since = 0;
    end else begin
      rise = sync_en && (ecount >= 4) && t0 && (prev_t0 == 0);
      if (!sync_en) begin
        if (mode >= 2) act = 2;
        mode = 0;
      end else begin
        case (mode)
          0: if (rise) begin m_ab = 0; hi = 1; mode = 1; end
          1: if (t0) begin
               hi++;
               if (hi == 4) begin mode = 2; act = 1; end
             end else begin
               mode = 0; m_ab = 1;
             end
          2: begin act = 1; if (!t0) begin mode = 3; waitc = 0; end end
          default: begin
            waitc++;
            if (waitc == 2) begin act = 2; mode = 0; end else act = 1;
          end
        endcase
      end
      ecount = sync_en ? ((ecount < 1000) ? ecount + 1 : ecount) : 0;
      prev_t0 = t0;
      if (act == 2) begin
        m_ts = 1; m_ph = 1; m_stb = 1; since = 0;
      end else if (act == 1) begin
        m_ts = 0; m_ph = 0; m_stb = 0; since = 0;
      end else begin
        m_ph++;
        if (m_ph > 3) begin m_ph = 1; m_ts++; if (m_ts > 5) m_ts = 1; end
        m_stb = (m_ts == 1 && m_ph == 1) ? 1 : 0;
        if (since < 100000) since++;
      end
      m_run = (!core_rst && since >= 75 && act == 0) ? 1 : 0;
    end
    started = 1;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_ne(input string tag, input string what, input int act, input int bad);
    checks++;
    if (act == bad) begin
      errors++;
      $display("FAIL %s %s actual %0d expected not %0d at %0t", tag, what, act, bad, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2", "tstate", int'(tstate), m_ts);
      chk("R2", "phase", int'(phase), m_ph);
      chk("R2", "cyc_stb", int'(cyc_stb), m_stb);
      chk("R8", "run_en", int'(run_en), m_run);
      chk("R7", "sync_abort", int'(sync_abort), m_ab);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1", "tstate", int'(tstate), 1);
    chk("R1", "phase", int'(phase), 1);
    chk("R1", "cyc_stb", int'(cyc_stb), 1);
    chk("R1", "run_en", int'(run_en), 0);
    chk("R1", "sync_abort", int'(sync_abort), 0);
    rst = 1'b0;

    // R2 free-running count and wrap
    tick(14);
    chk("R2", "tstate k14", int'(tstate), 5);
    chk("R2", "phase k14", int'(phase), 3);
    tick(1);
    chk("R2", "tstate wrap", int'(tstate), 1);
    chk("R2", "cyc_stb wrap", int'(cyc_stb), 1);

    // R8 run enable after 75 clocks, gated by core reset
    tick(59);
    chk("R8", "run_en k74", int'(run_en), 0);
    tick(1);
    chk("R8", "run_en k75", int'(run_en), 1);
    core_rst = 1'b1;
    tick(1);
    chk("R8", "run_en core held", int'(run_en), 0);
    core_rst = 1'b0;
    tick(1);
    chk("R8", "run_en core free", int'(run_en), 1);

    // R3 pulse outside sync mode ignored
    t0 = 1'b1;
    tick(6);
    chk_ne("R3", "phase", int'(phase), 0);
    t0 = 1'b0;
    tick(1);
    chk("R3", "sync_abort", int'(sync_abort), 0);
    chk("R3", "run_en", int'(run_en), 1);

    // R4 rise one clock too early is ignored
    sync_en = 1'b1;
    tick(3);
    t0 = 1'b1;
    tick(6);
    chk_ne("R4", "phase", int'(phase), 0);
    t0 = 1'b0;
    tick(2);

    // R5 / R6 full sync
    t0 = 1'b1;
    tick(3);
    chk_ne("R5", "phase after 3 highs", int'(phase), 0);
    tick(1);
    chk("R5", "tstate held", int'(tstate), 0);
    chk("R5", "phase held", int'(phase), 0);
    chk("R5", "run_en held", int'(run_en), 0);
    tick(5);
    chk("R5", "phase still held", int'(phase), 0);
    t0 = 1'b0;
    tick(1);
    chk("R6", "phase at fall", int'(phase), 0);
    tick(1);
    chk("R6", "phase at f+1", int'(phase), 0);
    tick(1);
    chk("R6", "tstate at f+2", int'(tstate), 1);
    chk("R6", "phase at f+2", int'(phase), 1);
    chk("R6", "cyc_stb at f+2", int'(cyc_stb), 1);
    tick(1);
    chk("R6", "phase resumes", int'(phase), 2);
    tick(73);
    chk("R8", "run_en A+74", int'(run_en), 0);
    tick(1);
    chk("R8", "run_en A+75", int'(run_en), 1);

    // R7 short pulse aborts
    t0 = 1'b1;
    tick(2);
    t0 = 1'b0;
    tick(1);
    chk("R7", "sync_abort set", int'(sync_abort), 1);
    chk_ne("R7", "phase kept", int'(phase), 0);
    chk("R7", "run_en kept", int'(run_en), 1);
    tick(2);
    chk("R7", "sync_abort sticky", int'(sync_abort), 1);

    // R9 sync mode leaves during clear; R7 flag cleared by new rise
    t0 = 1'b1;
    tick(4);
    chk("R9", "phase held", int'(phase), 0);
    chk("R7", "sync_abort cleared", int'(sync_abort), 0);
    sync_en = 1'b0;
    tick(1);
    chk("R9", "tstate aligned", int'(tstate), 1);
    chk("R9", "phase aligned", int'(phase), 1);
    chk("R9", "cyc_stb aligned", int'(cyc_stb), 1);
    t0 = 1'b0;
    tick(20);
    finish_run();
  end

endmodule